// File: doc/BRIEF.md
# Three-Channel Chainable Timer Block

This block holds three identical 16-bit timer channels that share one set of count-clock sources. Each channel takes its count pulses from one of five internal prescaled tick inputs or from one of three block-wide external clock lines. Block-level routing decides what drives each of those external lines. A line can follow the rising edges of an external pin, or it can take the event pulse of a neighbouring channel. An event pulse marks an overflow or an RC compare, so routing it onward chains two 16-bit channels into a wider counter.

Each channel is a small state machine with four states:
- `ST_STOP`: halted.
- `ST_CAP_A`: capture mode, the next selected edge on input A loads RA.
- `ST_CAP_B`: capture mode, the next selected edge on input A loads RB.
- `ST_WAVE`: waveform mode.

The transitions are these:
- A stop pulse moves any state to `ST_STOP`.
- A start pulse moves any state to `ST_CAP_A` or `ST_WAVE`, depending on the mode input at that moment.
- In capture mode, each selected edge on input A moves `ST_CAP_A` to `ST_CAP_B` and `ST_CAP_B` back to `ST_CAP_A`.

In capture mode a rising edge on input B clears the counter. In waveform mode:
- Output A is set by an RA compare and cleared by an RC compare.
- Output B toggles on each RC compare.
- An RC compare can optionally reset the counter, which gives up-counting PWM.

A block-wide start input starts all three channels on the same clock edge. Each channel raises a one-cycle interrupt pulse for the events that its enable bits allow.

Top module: `tmr_block`

## Requirements
- R1: After reset every counter, RA, RB, overflow flag, output A, output B and interrupt is 0, and every channel is stopped, so tick pulses do not change any counter.
- R2: A running channel adds one to its counter on each pulse of its selected clock. Clock select code 0..4 picks tick_int[code] and code 5..7 picks external line code-5. Stepping from 0xFFFF wraps to 0 and sets the sticky overflow flag.
- R3: A start pulse clears the counter, the overflow flag and both outputs, and enters the state that the mode input selects at that edge. A stop pulse halts the channel and the counter keeps its value. When start and stop arrive together, stop wins and nothing else happens on that edge.
- R4: A pulse on sync_start starts all three channels on the same edge, so all three counters read 0 after it.
- R5: In capture mode the selected edge on input A alternately loads RA and RB with the counter value from before that edge. The edge is rising when cap_fall is 0 and falling when it is 1.
- R6: In capture mode a rising edge on input B loads 0 into the counter on that edge, and this takes priority over a count step.
- R7: In waveform mode, a step taken while the counter equals RA sets output A. A step taken while it equals RC clears output A and toggles output B, and RC wins when both match. In capture mode both outputs stay 0.
- R8: In waveform mode with rc_reset set, a step taken at the RC value loads 0 in place of the increment.
- R9: The 2-bit route code of external line k selects its source: 0 is the rising edge of ext_in[k], 1 is the event pulse of channel k-1 (mod 3), 2 is the event pulse of channel k+1 (mod 3), and 3 is no source. An upstream overflow or RC compare steps the downstream channel exactly one clock later.
- R10: With route code 0, each rising edge on the external pin gives exactly one count step.
- R11: irq pulses for one cycle after each enabled event. Enable bit 0 is overflow, bit 1 is RA capture, bit 2 is RB capture and bit 3 is RC compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_int | input | 5 | Internal prescaled count pulses |
| ext_in | input | 3 | External clock pins |
| route_sel | input | 6 | Source code per external line, 2 bits each |
| sync_start | input | 1 | Start all channels |
| ch_start | input | 3 | Per-channel start pulse |
| ch_stop | input | 3 | Per-channel stop pulse |
| ch_wave | input | 3 | 1 waveform, 0 capture, sampled at start |
| ch_rc_reset | input | 3 | RC compare resets counter |
| ch_cap_fall | input | 3 | Capture on falling edge of A |
| ch_clk_sel | input | 9 | Clock select per channel, 3 bits each |
| ch_ra_cmp | input | 48 | RA compare value per channel |
| ch_rc_cmp | input | 48 | RC compare value per channel |
| ch_int_en | input | 12 | Interrupt enables per channel, 4 bits each |
| tio_a_in | input | 3 | Capture input A per channel |
| tio_b_in | input | 3 | Trigger input B per channel |
| cnt_o | output | 48 | Counter values |
| ra_cap_o | output | 48 | Captured RA values |
| rb_cap_o | output | 48 | Captured RB values |
| ovf_o | output | 3 | Sticky overflow flags |
| tio_a_out | output | 3 | Waveform output A |
| tio_b_out | output | 3 | Waveform output B |
| irq_o | output | 3 | Interrupt pulses |

## Verification
Every result comes from a register. A start, stop, count step, capture, trigger or compare shows at the ports after the first rising edge that samples the stimulus. A chained downstream channel moves one edge after its upstream channel's event, because the event pulse is itself registered. The bench drives inputs on the falling edge and runs a behavioural model on the rising edge. On each falling edge it compares every output against the model. Directed checks count whole cycles from the falling edge at which a stimulus was applied.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_CAP_A = 2'd1,
        ST_CAP_B = 2'd2,
        ST_WAVE  = 2'd3
    } chan_state_t;

    localparam int unsigned IRQ_W   = 4;
    localparam int unsigned IRQ_OVF = 0;
    localparam int unsigned IRQ_CPA = 1;
    localparam int unsigned IRQ_CPB = 2;
    localparam int unsigned IRQ_CPC = 3;
endpackage

// File: rtl/tmr_clksel.sv
`timescale 1ns/1ps
module tmr_clksel #(
    parameter int unsigned N_INT = 5,
    parameter int unsigned N_XC  = 3,
    parameter int unsigned SEL_W = 3
) (
    input  logic [N_INT-1:0] tick_i,
    input  logic [N_XC-1:0]  xc_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             step_o
);
    localparam int unsigned N_SRC = N_INT + N_XC;

    logic [N_SRC-1:0] src;
    assign src = {xc_i, tick_i};

    always_comb begin
        step_o = 1'b0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (sel_i == SEL_W'(i)) step_o = src[i];
        end
    end
endmodule

// File: rtl/tmr_route.sv
`timescale 1ns/1ps
module tmr_route #(
    parameter int unsigned N_CH = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_CH-1:0]   ext_i,
    input  logic [N_CH-1:0]   evt_i,
    input  logic [2*N_CH-1:0] sel_i,
    output logic [N_CH-1:0]   xc_o
);
    logic [N_CH-1:0] ext_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ext_q <= '0;
        else         ext_q <= ext_i;
    end

    for (genvar k = 0; k < int'(N_CH); k++) begin : g_line
        localparam int unsigned PREV = (k + N_CH - 1) % N_CH;
        localparam int unsigned NEXT = (k + 1) % N_CH;
        logic line;
        always_comb begin
            unique case (sel_i[2*k +: 2])
                2'd0:    line = ext_i[k] & ~ext_q[k];
                2'd1:    line = evt_i[PREV];
                2'd2:    line = evt_i[NEXT];
                default: line = 1'b0;
            endcase
        end
        assign xc_o[k] = line;

        AST_PIN_EDGE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel_i[2*k +: 2] == 2'd0) && line |=> !line || (sel_i[2*k +: 2] != 2'd0)); // R10
    end
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_INT = 5,
    parameter int unsigned N_XC  = 3,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_INT-1:0] tick_i,
    input  logic [N_XC-1:0]  xc_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             wave_i,
    input  logic             rc_rst_i,
    input  logic             cap_fall_i,
    input  logic [CNT_W-1:0] ra_cmp_i,
    input  logic [CNT_W-1:0] rc_cmp_i,
    input  logic [IRQ_W-1:0] int_en_i,
    input  logic             tio_a_i,
    input  logic             tio_b_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] ra_cap_o,
    output logic [CNT_W-1:0] rb_cap_o,
    output logic             ovf_o,
    output logic             tio_a_o,
    output logic             tio_b_o,
    output logic             evt_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    chan_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_q, ra_q, rb_q;
    logic ovf_q, a_out_q, b_out_q, evt_q, irq_q, a_q, b_q;
    logic step, edge_a, edge_b, go, capturing, waving;
    logic hit_a, hit_c, trig, wrap, cap_a, cap_b;
    logic [IRQ_W-1:0] events;

    tmr_clksel #(.N_INT(N_INT), .N_XC(N_XC), .SEL_W(SEL_W)) u_sel (
        .tick_i (tick_i),
        .xc_i   (xc_i),
        .sel_i  (clk_sel_i),
        .step_o (step)
    );

    assign edge_a    = cap_fall_i ? (a_q & ~tio_a_i) : (~a_q & tio_a_i);
    assign edge_b    = ~b_q & tio_b_i;
    assign go        = (st_q != ST_STOP) && !start_i && !stop_i;
    assign capturing = (st_q == ST_CAP_A) || (st_q == ST_CAP_B);
    assign waving    = (st_q == ST_WAVE);
    assign hit_c     = go && waving && step && (cnt_q == rc_cmp_i);
    assign hit_a     = go && waving && step && (cnt_q == ra_cmp_i);
    assign trig      = go && capturing && edge_b;
    assign wrap      = go && step && !trig && !(hit_c && rc_rst_i) && (cnt_q == MAXV);
    assign cap_a     = go && (st_q == ST_CAP_A) && edge_a;
    assign cap_b     = go && (st_q == ST_CAP_B) && edge_a;

    always_comb begin
        events          = '0;
        events[IRQ_OVF] = wrap;
        events[IRQ_CPA] = cap_a;
        events[IRQ_CPB] = cap_b;
        events[IRQ_CPC] = hit_c;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (stop_i) begin
            st_d = ST_STOP;
        end else if (start_i) begin
            st_d = wave_i ? ST_WAVE : ST_CAP_A;
        end else begin
            unique case (st_q)
                ST_CAP_A: if (edge_a) st_d = ST_CAP_B;
                ST_CAP_B: if (edge_a) st_d = ST_CAP_A;
                ST_STOP:  st_d = ST_STOP;
                ST_WAVE:  st_d = ST_WAVE;
                default:  st_d = ST_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_STOP;
        else         st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            ra_q    <= '0;
            rb_q    <= '0;
            ovf_q   <= 1'b0;
            a_out_q <= 1'b0;
            b_out_q <= 1'b0;
            evt_q   <= 1'b0;
            irq_q   <= 1'b0;
            a_q     <= 1'b0;
            b_q     <= 1'b0;
        end else begin
            a_q   <= tio_a_i;
            b_q   <= tio_b_i;
            evt_q <= wrap | hit_c;
            irq_q <= |(events & int_en_i);
            if (start_i && !stop_i) begin
                cnt_q   <= '0;
                ovf_q   <= 1'b0;
                a_out_q <= 1'b0;
                b_out_q <= 1'b0;
            end else if (go) begin
                if (trig)                      cnt_q <= '0;
                else if (step && hit_c && rc_rst_i) cnt_q <= '0;
                else if (step)                 cnt_q <= cnt_q + 1'b1;
                if (wrap)  ovf_q <= 1'b1;
                if (cap_a) ra_q  <= cnt_q;
                if (cap_b) rb_q  <= cnt_q;
                if (hit_c)      a_out_q <= 1'b0;
                else if (hit_a) a_out_q <= 1'b1;
                if (hit_c) b_out_q <= ~b_out_q;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign ra_cap_o = ra_q;
    assign rb_cap_o = rb_q;
    assign ovf_o    = ovf_q;
    assign tio_a_o  = a_out_q;
    assign tio_b_o  = b_out_q;
    assign evt_o    = evt_q;
    assign irq_o    = irq_q;

    AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_STOP) && !start_i |=> $stable(cnt_q)); // R3
    AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go && step && !trig && !(hit_c && rc_rst_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_q && !(start_i && !stop_i) |=> ovf_q); // R2
    AST_CAPTURE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capturing |-> !a_out_q && !b_out_q); // R7
    AST_CAP_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_a |=> st_q == ST_CAP_B); // R5
    AST_RC_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_c && rc_rst_i |=> cnt_q == '0); // R8
    AST_TRIG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig |=> cnt_q == '0); // R6
endmodule

// File: rtl/tmr_block.sv
`timescale 1ns/1ps
module tmr_block
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_CH  = 3,
    parameter int unsigned N_INT = 5,
    parameter int unsigned SEL_W = $clog2(N_INT + N_CH)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_INT-1:0]        tick_int,
    input  logic [N_CH-1:0]         ext_in,
    input  logic [2*N_CH-1:0]       route_sel,
    input  logic                    sync_start,
    input  logic [N_CH-1:0]         ch_start,
    input  logic [N_CH-1:0]         ch_stop,
    input  logic [N_CH-1:0]         ch_wave,
    input  logic [N_CH-1:0]         ch_rc_reset,
    input  logic [N_CH-1:0]         ch_cap_fall,
    input  logic [N_CH*SEL_W-1:0]   ch_clk_sel,
    input  logic [N_CH*CNT_W-1:0]   ch_ra_cmp,
    input  logic [N_CH*CNT_W-1:0]   ch_rc_cmp,
    input  logic [N_CH*IRQ_W-1:0]   ch_int_en,
    input  logic [N_CH-1:0]         tio_a_in,
    input  logic [N_CH-1:0]         tio_b_in,
    output logic [N_CH*CNT_W-1:0]   cnt_o,
    output logic [N_CH*CNT_W-1:0]   ra_cap_o,
    output logic [N_CH*CNT_W-1:0]   rb_cap_o,
    output logic [N_CH-1:0]         ovf_o,
    output logic [N_CH-1:0]         tio_a_out,
    output logic [N_CH-1:0]         tio_b_out,
    output logic [N_CH-1:0]         irq_o
);
    logic [N_CH-1:0] xc;
    logic [N_CH-1:0] evt;

    tmr_route #(.N_CH(N_CH)) u_route (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ext_i  (ext_in),
        .evt_i  (evt),
        .sel_i  (route_sel),
        .xc_o   (xc)
    );

    for (genvar g = 0; g < int'(N_CH); g++) begin : g_ch
        tmr_chan #(.CNT_W(CNT_W), .N_INT(N_INT), .N_XC(N_CH), .SEL_W(SEL_W)) u_ch (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .tick_i     (tick_int),
            .xc_i       (xc),
            .clk_sel_i  (ch_clk_sel[g*SEL_W +: SEL_W]),
            .start_i    (ch_start[g] | sync_start),
            .stop_i     (ch_stop[g]),
            .wave_i     (ch_wave[g]),
            .rc_rst_i   (ch_rc_reset[g]),
            .cap_fall_i (ch_cap_fall[g]),
            .ra_cmp_i   (ch_ra_cmp[g*CNT_W +: CNT_W]),
            .rc_cmp_i   (ch_rc_cmp[g*CNT_W +: CNT_W]),
            .int_en_i   (ch_int_en[g*IRQ_W +: IRQ_W]),
            .tio_a_i    (tio_a_in[g]),
            .tio_b_i    (tio_b_in[g]),
            .cnt_o      (cnt_o[g*CNT_W +: CNT_W]),
            .ra_cap_o   (ra_cap_o[g*CNT_W +: CNT_W]),
            .rb_cap_o   (rb_cap_o[g*CNT_W +: CNT_W]),
            .ovf_o      (ovf_o[g]),
            .tio_a_o    (tio_a_out[g]),
            .tio_b_o    (tio_b_out[g]),
            .evt_o      (evt[g]),
            .irq_o      (irq_o[g])
        );
    end

    AST_SYNC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_start && (ch_stop == '0) |=> cnt_o == '0); // R4
endmodule

// File: tb/tmr_block_tb.sv
`timescale 1ns/1ps
module tmr_block_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tick_int = '0;
    logic [2:0]  ext_in = '0;
    logic [5:0]  route_sel = '0;
    logic        sync_start = 1'b0;
    logic [2:0]  ch_start = '0, ch_stop = '0, ch_wave = '0, ch_rc_reset = '0, ch_cap_fall = '0;
    logic [8:0]  ch_clk_sel = '0;
    logic [47:0] ch_ra_cmp = '0, ch_rc_cmp = '0;
    logic [11:0] ch_int_en = '0;
    logic [2:0]  tio_a_in = '0, tio_b_in = '0;
    logic [47:0] cnt_o, ra_cap_o, rb_cap_o;
    logic [2:0]  ovf_o, tio_a_out, tio_b_out, irq_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    tmr_block u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_int(tick_int), .ext_in(ext_in),
        .route_sel(route_sel), .sync_start(sync_start), .ch_start(ch_start),
        .ch_stop(ch_stop), .ch_wave(ch_wave), .ch_rc_reset(ch_rc_reset),
        .ch_cap_fall(ch_cap_fall), .ch_clk_sel(ch_clk_sel), .ch_ra_cmp(ch_ra_cmp),
        .ch_rc_cmp(ch_rc_cmp), .ch_int_en(ch_int_en), .tio_a_in(tio_a_in),
        .tio_b_in(tio_b_in), .cnt_o(cnt_o), .ra_cap_o(ra_cap_o), .rb_cap_o(rb_cap_o),
        .ovf_o(ovf_o), .tio_a_out(tio_a_out), .tio_b_out(tio_b_out), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_cnt[3], m_ra[3], m_rb[3], m_st[3];
    bit m_ovf[3], m_ao[3], m_bo[3], m_evt[3], m_irq[3], m_aq[3], m_bq[3], m_extq[3];
    bit t_xc[3];
    int t_sel, t_code;
    bit t_step, t_ea, t_eb, t_strt, t_stp, t_go, t_wv, t_cp, t_hc, t_ha, t_tr, t_wr, t_ca, t_cb;
    logic [3:0] t_en;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                m_cnt[c] = 0; m_ra[c] = 0; m_rb[c] = 0; m_st[c] = 0;
                m_ovf[c] = 0; m_ao[c] = 0; m_bo[c] = 0; m_evt[c] = 0;
                m_irq[c] = 0; m_aq[c] = 0; m_bq[c] = 0; m_extq[c] = 0;
            end
        end else begin
            for (int k = 0; k < 3; k++) begin
                t_code = int'(route_sel[2*k +: 2]);
                if (t_code == 0)      t_xc[k] = ext_in[k] && !m_extq[k];
                else if (t_code == 1) t_xc[k] = m_evt[(k+2)%3];
                else if (t_code == 2) t_xc[k] = m_evt[(k+1)%3];
                else                  t_xc[k] = 1'b0;
            end
            for (int c = 0; c < 3; c++) begin
                t_sel  = int'(ch_clk_sel[3*c +: 3]);
                t_step = (t_sel < 5) ? tick_int[t_sel] : t_xc[t_sel-5];
                t_ea   = ch_cap_fall[c] ? (m_aq[c] && !tio_a_in[c]) : (!m_aq[c] && tio_a_in[c]);
                t_eb   = !m_bq[c] && tio_b_in[c];
                t_strt = ch_start[c] || sync_start;
                t_stp  = ch_stop[c];
                t_go   = (m_st[c] != 0) && !t_strt && !t_stp;
                t_wv   = (m_st[c] == 3);
                t_cp   = (m_st[c] == 1) || (m_st[c] == 2);
                t_hc   = t_go && t_wv && t_step && (m_cnt[c] == int'(ch_rc_cmp[16*c +: 16]));
                t_ha   = t_go && t_wv && t_step && (m_cnt[c] == int'(ch_ra_cmp[16*c +: 16]));
                t_tr   = t_go && t_cp && t_eb;
                t_wr   = t_go && t_step && !t_tr && !(t_hc && ch_rc_reset[c]) && (m_cnt[c] == 65535);
                t_ca   = t_go && (m_st[c] == 1) && t_ea;
                t_cb   = t_go && (m_st[c] == 2) && t_ea;
                t_en   = ch_int_en[4*c +: 4];
                m_evt[c] = t_wr || t_hc;
                m_irq[c] = (t_wr && t_en[0]) || (t_ca && t_en[1]) || (t_cb && t_en[2]) || (t_hc && t_en[3]);
                if (t_stp) begin
                    m_st[c] = 0;
                end else if (t_strt) begin
                    m_st[c] = ch_wave[c] ? 3 : 1;
                    m_cnt[c] = 0; m_ovf[c] = 0; m_ao[c] = 0; m_bo[c] = 0;
                end else if (t_go) begin
                    if (t_ca) m_ra[c] = m_cnt[c];
                    if (t_cb) m_rb[c] = m_cnt[c];
                    if (t_hc) begin m_ao[c] = 0; m_bo[c] = !m_bo[c]; end
                    else if (t_ha) m_ao[c] = 1;
                    if (t_wr) m_ovf[c] = 1;
                    if (t_tr) m_cnt[c] = 0;
                    else if (t_step) m_cnt[c] = (t_hc && ch_rc_reset[c]) ? 0 : ((m_cnt[c] + 1) & 65535);
                    if (t_cp && t_ea) m_st[c] = (m_st[c] == 1) ? 2 : 1;
                end
                m_aq[c] = tio_a_in[c];
                m_bq[c] = tio_b_in[c];
            end
            for (int k = 0; k < 3; k++) m_extq[k] = ext_in[k];
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            for (int c = 0; c < 3; c++) begin
                chk("R2",  "cnt",   int'(cnt_o[16*c +: 16]),    m_cnt[c]);
                chk("R5",  "ra",    int'(ra_cap_o[16*c +: 16]), m_ra[c]);
                chk("R5",  "rb",    int'(rb_cap_o[16*c +: 16]), m_rb[c]);
                chk("R2",  "ovf",   int'(ovf_o[c]),             int'(m_ovf[c]));
                chk("R7",  "out_a", int'(tio_a_out[c]),         int'(m_ao[c]));
                chk("R7",  "out_b", int'(tio_b_out[c]),         int'(m_bo[c]));
                chk("R11", "irq",   int'(irq_o[c]),             int'(m_irq[c]));
            end
        end
    end

    // tick pattern: rates 1, 1/2, 1/4, 1/8, 1/16
    int tc = 0;
    always @(negedge clk) begin
        tc++;
        tick_int = {tc % 16 == 0, tc % 8 == 0, tc % 4 == 0, tc % 2 == 0, 1'b1};
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(int c);
        ch_start[c] = 1'b1; cyc(1); ch_start[c] = 1'b0;
    endtask

    task automatic pulse_stop(int c);
        ch_stop[c] = 1'b1; cyc(1); ch_stop[c] = 1'b0;
    endtask

    task automatic pulse_sync();
        sync_start = 1'b1; cyc(1); sync_start = 1'b0;
    endtask

    function automatic int cnt_of(int c);
        return int'(cnt_o[16*c +: 16]);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired before the run ended");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        // R1: stopped after reset, ticks do nothing
        for (int c = 0; c < 3; c++) begin
            chk("R1", "reset cnt",  cnt_of(c), 0);
            chk("R1", "reset outs", int'({tio_a_out[c], tio_b_out[c], ovf_o[c], irq_o[c]}), 0);
        end

        // R2 / R3: count, stop, start+stop
        ch_clk_sel[2:0] = 3'd0;
        pulse_start(0);
        chk("R3", "cnt after start", cnt_of(0), 0);
        cyc(10);
        chk("R2", "cnt after 10 ticks", cnt_of(0), 10);
        pulse_stop(0);
        cyc(4);
        chk("R3", "cnt held while stopped", cnt_of(0), 10);
        ch_start[0] = 1'b1; ch_stop[0] = 1'b1; cyc(1);
        ch_start[0] = 1'b0; ch_stop[0] = 1'b0; cyc(3);
        chk("R3", "stop wins over start", cnt_of(0), 10);

        // R4: synchronous start
        ch_wave = 3'b111;
        ch_ra_cmp = {3{16'hFFFF}};
        ch_rc_cmp = {3{16'hFFFF}};
        ch_clk_sel = {3'd0, 3'd1, 3'd0};
        pulse_sync();
        for (int c = 0; c < 3; c++) chk("R4", "cnt after sync start", cnt_of(c), 0);
        cyc(8);
        chk("R4", "ch0 after 8", cnt_of(0), 8);
        chk("R4", "ch2 equals ch0", cnt_of(2), cnt_of(0));

        // R5 / R6: capture on channel 0
        ch_wave[0] = 1'b0; ch_cap_fall[0] = 1'b0;
        pulse_start(0);
        cyc(5);
        tio_a_in[0] = 1'b1; cyc(1);
        chk("R5", "RA captured", int'(ra_cap_o[15:0]), 5);
        cyc(3); tio_a_in[0] = 1'b0; cyc(2); tio_a_in[0] = 1'b1; cyc(1);
        chk("R5", "RB captured", int'(rb_cap_o[15:0]), 11);
        tio_b_in[0] = 1'b1; cyc(1);
        chk("R6", "trigger clears counter", cnt_of(0), 0);
        tio_b_in[0] = 1'b0;
        ch_cap_fall[0] = 1'b1;
        cyc(4); tio_a_in[0] = 1'b0; cyc(3); tio_a_in[0] = 1'b1; cyc(2); tio_a_in[0] = 1'b0; cyc(2);

        // R7 / R8 / R11: waveform on channel 1
        ch_wave[1] = 1'b1; ch_rc_reset[1] = 1'b1; ch_clk_sel[5:3] = 3'd0;
        ch_ra_cmp[31:16] = 16'd2; ch_rc_cmp[31:16] = 16'd5; ch_int_en[7:4] = 4'b1000;
        pulse_start(1);
        cyc(3);
        chk("R7", "out A set at RA", int'(tio_a_out[1]), 1);
        chk("R7", "cnt at 3", cnt_of(1), 3);
        cyc(3);
        chk("R8", "RC reset to 0", cnt_of(1), 0);
        chk("R7", "out A cleared at RC", int'(tio_a_out[1]), 0);
        chk("R7", "out B toggled", int'(tio_b_out[1]), 1);
        chk("R11", "RC irq pulse", int'(irq_o[1]), 1);
        cyc(20);

        // R9: chain channel 2 events into channel 1
        ch_wave[2] = 1'b1; ch_rc_reset[2] = 1'b1; ch_clk_sel[8:6] = 3'd0;
        ch_ra_cmp[47:32] = 16'd0; ch_rc_cmp[47:32] = 16'd3;
        ch_wave[1] = 1'b0; ch_clk_sel[5:3] = 3'd6; route_sel[3:2] = 2'd2;
        pulse_sync();
        cyc(4);
        chk("R9", "downstream before event", cnt_of(1), 0);
        cyc(1);
        chk("R9", "downstream one clock after event", cnt_of(1), 1);
        cyc(20);

        // R10: external pin clocks channel 0 via line 2
        route_sel[5:4] = 2'd0; ch_clk_sel[2:0] = 3'd7; ch_wave[0] = 1'b0;
        pulse_start(0);
        for (int i = 0; i < 3; i++) begin
            ext_in[2] = 1'b1; cyc(1); ext_in[2] = 1'b0; cyc(1);
        end
        cyc(2);
        chk("R10", "three pin edges", cnt_of(0), 3);

        // R2 / R11: full wrap on channel 0
        ch_clk_sel[2:0] = 3'd0; ch_int_en[3:0] = 4'b0001;
        pulse_start(0);
        cyc(65535);
        chk("R2", "cnt at max", cnt_of(0), 65535);
        chk("R2", "no ovf yet", int'(ovf_o[0]), 0);
        cyc(1);
        chk("R2", "wrap to 0", cnt_of(0), 0);
        chk("R2", "ovf set", int'(ovf_o[0]), 1);
        chk("R11", "ovf irq", int'(irq_o[0]), 1);
        cyc(1);
        chk("R11", "irq one cycle", int'(irq_o[0]), 0);
        chk("R2", "ovf sticky", int'(ovf_o[0]), 1);
        pulse_start(0);
        chk("R3", "start clears ovf", int'(ovf_o[0]), 0);
        cyc(2);
        finish_run();
    end
endmodule